// File: doc/BRIEF.md
# Byte-Lane Asynchronous Static Memory Controller

This block sits between a synchronous host and an external asynchronous static memory. The memory is one million words deep and 32 bits wide. The host offers one word access at a time over a valid/ready port. Each request carries an address, a write flag, write data and an active-high 4-bit byte mask. The controller converts the request into a timed sequence on the memory pins: a shared active-low chip select, output enable and write enable, plus four active-low byte strobes. It also decides when its own data drivers are on. The read access length, the write pulse length and the read-to-write gap are parameters counted in clock cycles.

A read keeps chip select and output enable low for the access window. On the last cycle of that window the controller samples the lanes that were selected. It returns them with a one-cycle valid pulse and forces the unselected lanes to zero. A write drives data from its first cycle. It holds write enable low for the pulse width. It ends the write by raising write enable while chip select, the byte strobes and the data drive are kept for one more cycle. When a write follows a read, idle cycles with every strobe high come first, so the memory can release the bus before the controller drives it.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, chip select, output enable, write enable and all four byte strobes are high (1), and `mem_dq_oe` is 0.
- R2: A read keeps `mem_cs_n` and `mem_oe_n` at 0 and `mem_we_n` at 1 for exactly RD_CYC cycles. During that time `mem_bs_n[i]` is the inverse of mask bit i, and `mem_addr` equals the request address and does not change.
- R3: One cycle after the read window ends, `rsp_valid` is 1 for a single cycle. Lane i of `rsp_rdata` (bits 8i+7:8i, gated by `mem_bs_n[i]`) holds the memory data when mask bit i is 1 and zero when it is 0.
- R4: A write keeps `mem_cs_n` and `mem_we_n` at 0 and `mem_oe_n` at 1 for exactly WR_CYC cycles. `mem_bs_n` is the inverse of the mask, `mem_dq_oe` is 1, and `mem_dq_out` equals the write data throughout. Only the masked lanes of the addressed word change.
- R5: A write is ended by write enable. In the first cycle after `mem_we_n` returns to 1, `mem_cs_n` is still 0 and `mem_dq_oe` is still 1. In the cycle after that, all strobes are high and the bus is released.
- R6: A write whose previous access was a read is preceded by exactly TURN_CYC cycles with all strobes high and `mem_dq_oe` at 0. A write that follows a write gets no such gap.
- R7: `mem_dq_oe` is never 1 in a cycle where `mem_cs_n` and `mem_oe_n` are 0 and `mem_we_n` is 1. It is also 0 in the cycle after any cycle with `mem_oe_n` at 0.
- R8: `req_ready` is 1 only when the controller is idle, with chip select high and the bus released. A request is taken only in a cycle where both `req_valid` and `req_ready` are 1. While the host holds `req_valid` low, no strobe moves.
- R9: A request with an all-zero mask keeps every byte strobe high. A write with that mask leaves the word unchanged, and a read with it returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request taken this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 32 | Write data |
| req_mask | input | 4 | Active-high byte mask, bit i covers bits 8i+7:8i |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 32 | Read data, unselected lanes zero |
| mem_addr | output | 20 | Memory address |
| mem_dq_in | input | 32 | Data bus as seen from the memory |
| mem_dq_out | output | 32 | Data the controller drives |
| mem_dq_oe | output | 1 | 1 = controller drives the data bus |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_bs_n | output | 4 | Byte strobes, active low, bit i gates lane i |

## Verification
The hardest case to reach is the read-to-write turnaround, together with the timing of the write's trailing edge. The gap exists only when a write arrives after a read. The bench's vector table therefore alternates reads and writes, so that writes follow both reads and writes, and it counts the gap cycles on each write. A memory model in the bench floats unselected lanes to a non-zero filler and commits writes only on selected lanes. Partial masks, and a zero mask on both a read and a write, therefore show up in later read-backs.

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 32,
  parameter int RD_CYC   = 2,
  parameter int WR_CYC   = 2,
  parameter int TURN_CYC = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [DATA_W/8-1:0]   req_mask,
  output logic                  rsp_valid,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic [ADDR_W-1:0]     mem_addr,
  input  logic [DATA_W-1:0]     mem_dq_in,
  output logic [DATA_W-1:0]     mem_dq_out,
  output logic                  mem_dq_oe,
  output logic                  mem_cs_n,
  output logic                  mem_oe_n,
  output logic                  mem_we_n,
  output logic [DATA_W/8-1:0]   mem_bs_n
);

  localparam int LANES = DATA_W / 8;
  localparam int MAXC  = (RD_CYC > WR_CYC) ? ((RD_CYC > TURN_CYC) ? RD_CYC : TURN_CYC)
                                           : ((WR_CYC > TURN_CYC) ? WR_CYC : TURN_CYC);
  localparam int CNT_W = $clog2(MAXC + 1) + 1;
  localparam logic [CNT_W-1:0] RD_LD = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LD = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] TN_LD = CNT_W'(TURN_CYC - 1);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_TURN, S_WR, S_WEND} st_t;

  st_t                st;
  logic [CNT_W-1:0]   cnt;
  logic               rd_flag;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  wdata_q;
  logic [LANES-1:0]   mask_q;
  logic [DATA_W-1:0]  keep;

  for (genvar i = 0; i < LANES; i++) begin : g_keep
    assign keep[8*i +: 8] = {8{mask_q[i]}};
  end

  wire active = (st == S_RD) || (st == S_WR) || (st == S_WEND);

  assign req_ready  = (st == S_IDLE);
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = (st == S_WR) || (st == S_WEND);
  assign mem_cs_n   = !active;
  assign mem_oe_n   = (st != S_RD);
  assign mem_we_n   = (st != S_WR);
  assign mem_bs_n   = active ? ~mask_q : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      rd_flag   <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      mask_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          mask_q  <= req_mask;
          if (!req_write) begin
            st  <= S_RD;
            cnt <= RD_LD;
          end else if (rd_flag) begin
            st  <= S_TURN;
            cnt <= TN_LD;
          end else begin
            st  <= S_WR;
            cnt <= WR_LD;
          end
        end
        S_RD: if (cnt == '0) begin
          rsp_valid <= 1'b1;
          rsp_rdata <= mem_dq_in & keep;
          rd_flag   <= 1'b1;
          st        <= S_IDLE;
        end else cnt <= cnt - 1'b1;
        S_TURN: if (cnt == '0) begin
          st  <= S_WR;
          cnt <= WR_LD;
        end else cnt <= cnt - 1'b1;
        S_WR: begin
          rd_flag <= 1'b0;
          if (cnt == '0) st <= S_WEND;
          else cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [CNT_W-1:0] we_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_run <= '0;
    else if (!mem_we_n) we_run <= we_run + 1'b1;
    else we_run <= '0;
  end

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_cs_n && !mem_oe_n && mem_we_n)); // R7
  AST_TURN_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |=> !mem_dq_oe); // R7
  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_run == WR_LD + 1'b1)); // R4
  AST_WE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (!mem_cs_n && mem_dq_oe)); // R5
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr)); // R2
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R3
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && !mem_dq_oe)); // R8

endmodule

// File: tb/test_sram_lane_ctrl.sv
module test_sram_lane_ctrl;
  localparam int RD_CYC = 2, WR_CYC = 2, TURN_CYC = 1;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [19:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_mask = '0;
  logic req_ready, rsp_valid, mem_dq_oe, mem_cs_n, mem_oe_n, mem_we_n;
  logic [31:0] rsp_rdata, mem_dq_in, mem_dq_out;
  logic [19:0] mem_addr;
  logic [3:0]  mem_bs_n;

  always #5 clk = ~clk;

  sram_lane_ctrl #(.RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .TURN_CYC(TURN_CYC)) i_sram_lane_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_dq_in(mem_dq_in),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_bs_n(mem_bs_n));

  logic [31:0] mem [0:15];
  always_comb begin
    for (int i = 0; i < 4; i++)
      mem_dq_in[8*i +: 8] = (!mem_cs_n && !mem_oe_n && mem_we_n && !mem_bs_n[i])
                            ? mem[mem_addr[3:0]][8*i +: 8] : 8'hEE;
  end
  always @(negedge clk)
    if (rst_n && !mem_cs_n && !mem_we_n)
      for (int i = 0; i < 4; i++)
        if (!mem_bs_n[i]) mem[mem_addr[3:0]][8*i +: 8] <= mem_dq_out[8*i +: 8];

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk)
    if (rst_n && mem_dq_oe && !mem_cs_n && !mem_oe_n && mem_we_n) begin
      n_bad++;
      $display("FAIL R7 contention actual=%h expected=%h", 1, 0);
    end

  localparam int NV = 13;
  localparam logic [88:0] VEC [0:NV-1] = '{
    {1'b1, 20'h00003, 32'h11223344, 4'hF, 32'h0},
    {1'b1, 20'h00005, 32'hAABBCCDD, 4'hF, 32'h0},
    {1'b0, 20'h00003, 32'h0,        4'hF, 32'h11223344},
    {1'b1, 20'h00003, 32'h55667788, 4'h5, 32'h0},
    {1'b0, 20'h00003, 32'h0,        4'hF, 32'h11663388},
    {1'b0, 20'h00005, 32'h0,        4'hA, 32'hAA00CC00},
    {1'b1, 20'h00005, 32'h00000000, 4'h8, 32'h0},
    {1'b0, 20'h00005, 32'h0,        4'hF, 32'h00BBCCDD},
    {1'b0, 20'h00003, 32'h0,        4'h0, 32'h00000000},
    {1'b1, 20'h00003, 32'hFFFFFFFF, 4'h0, 32'h0},
    {1'b0, 20'h00003, 32'h0,        4'hF, 32'h11663388},
    {1'b1, 20'hFFFFF, 32'h12345678, 4'hF, 32'h0},
    {1'b0, 20'hFFFFF, 32'h0,        4'h3, 32'h00005678}
  };

  bit prev_rd = 0;

  task automatic run_op(input logic wr, input logic [19:0] a, input logic [31:0] d,
                        input logic [3:0] m, input logic [31:0] exp);
    int n_oe = 0, n_we = 0, n_turn = 0, guard = 0;
    bit seen_we = 0, prev_we = 0, strobe_ok = 1, end_ok = 1, wend_seen = 0;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    while (!req_ready && guard < 50) begin
      guard++;
      if (!mem_oe_n) begin
        n_oe++;
        if (mem_cs_n || !mem_we_n || mem_bs_n != ~m || mem_addr != a) strobe_ok = 0;
      end
      if (!mem_we_n) begin
        n_we++; seen_we = 1;
        if (mem_cs_n || !mem_oe_n || mem_bs_n != ~m || !mem_dq_oe || mem_dq_out != d) strobe_ok = 0;
      end else if (prev_we) begin
        wend_seen = 1;
        if (mem_cs_n || !mem_dq_oe) end_ok = 0;
      end
      if (wr && !seen_we && mem_cs_n && !mem_dq_oe && mem_we_n) n_turn++;
      prev_we = !mem_we_n;
      @(negedge clk);
    end
    chk(guard < 50, "R8 op completes", guard, 0);
    if (wr) begin
      chk(n_we == WR_CYC, "R4 write pulse cycles", n_we, WR_CYC);
      chk(strobe_ok, "R4 write strobes/data", mem_bs_n, ~m);
      chk(wend_seen && end_ok, "R5 write ended by WE", end_ok, 1);
      chk(n_turn == (prev_rd ? TURN_CYC : 0), "R6 turnaround cycles", n_turn, prev_rd ? TURN_CYC : 0);
      chk(mem_cs_n && !mem_dq_oe, "R5 released after write", mem_dq_oe, 0);
    end else begin
      chk(n_oe == RD_CYC, "R2 read window cycles", n_oe, RD_CYC);
      chk(strobe_ok, "R2 read strobes/address", mem_bs_n, ~m);
      chk(rsp_valid, "R3 rsp_valid pulse", rsp_valid, 1);
      chk(rsp_rdata == exp, m == 0 ? "R9 zero-mask read" : "R3 read data", rsp_rdata, exp);
      @(negedge clk);
      chk(!rsp_valid, "R3 single-cycle valid", rsp_valid, 0);
    end
    prev_rd = !wr;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'h0;
    #23;
    chk(req_ready == 1 && rsp_valid == 0, "R1 reset handshake", {req_ready, rsp_valid}, 2'b10);
    chk({mem_cs_n, mem_oe_n, mem_we_n, mem_bs_n} == 7'h7F && !mem_dq_oe, "R1 reset strobes",
        {mem_dq_oe, mem_cs_n, mem_oe_n, mem_we_n, mem_bs_n}, 8'h7F);
    rst_n = 1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(mem_cs_n && mem_bs_n == 4'hF && req_ready, "R8 idle without valid", mem_cs_n, 1);
    end
    for (int v = 0; v < NV; v++)
      run_op(VEC[v][88], VEC[v][87:68], VEC[v][67:36], VEC[v][35:32], VEC[v][31:0]);
    chk(mem[3] == 32'h11663388, "R9 zero-mask write left word", mem[3], 32'h11663388);
    run_op(1'b1, 20'h00007, 32'hCAFE0001, 4'hF, 32'h0);
    run_op(1'b1, 20'h00007, 32'h0000BEEF, 4'h3, 32'h0);
    run_op(1'b0, 20'h00007, 32'h0, 4'hF, 32'hCAFEBEEF);
    repeat (4) @(negedge clk);
    run_op(1'b1, 20'h00007, 32'h11000000, 4'h8, 32'h0);
    run_op(1'b0, 20'h00007, 32'h0, 4'hC, 32'h11FE0000);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule